// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the state update a processor core needs when it enters an exception. A general request carries a cause code and the faulting PC, and optionally a faulting virtual address. A debug request carries a cause code and the PC. The block reads the current processor-status fields: interrupt level, user mode and exception mode. It then decides which vector to use, writes the save registers, and produces the new processor-status value. All of this happens in a single clock edge.

The core keeps its own processor-status register. It loads `ps_*_o` when `taken_o` pulses, and it fetches from the vector reported on `vector_o`. A general request raised while exception mode is already set becomes a double exception, which has its own PC save register. A debug request is accepted only below a configured debug level. It saves the whole old status word into a per-level save slot and raises the interrupt level to the debug level.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, all of these outputs are zero: `taken_o`, `vector_o` (kernel), the status outputs, every EPC and EPS slot, `depc_o`, `exccause_o`, `excvaddr_o` and `debugcause_o`.
- R2: An accepted general request with `ps_excm_i`=0 stores `pc_i` in EPC level 1, which is bits [XLEN-1:0] of `epc_flat_o`. The vector is user (code 1) when `ps_um_i`=1 and kernel (code 0) when it is 0.
- R3: An accepted general request with `ps_excm_i`=1 selects the double vector (code 2). When HAS_DEPC=1 it stores `pc_i` in `depc_o` and leaves EPC level 1 unchanged. When HAS_DEPC=0 it stores `pc_i` in EPC level 1.
- R4: Every accepted general request stores `cause_i` in `exccause_o`. It drives `ps_excm_o`=1 and passes `ps_um_i` and `ps_intlevel_i` through unchanged.
- R5: `excvaddr_o` takes `vaddr_i` only on an accepted general request with `gen_addr_vld_i`=1. Otherwise it holds its value.
- R6: A debug request with `ps_intlevel_i` < DBG_LEVEL is accepted, with the following effects:
  - The vector is debug (code 3).
  - `debugcause_o` takes `cause_i`.
  - EPC slot DBG_LEVEL takes `pc_i`. Slot l sits at bits [(l-1)*XLEN +: XLEN].
  - EPS slot DBG_LEVEL takes the old status word {intlevel, um, excm}, with excm in bit 0. Slot l sits at bits [(l-1)*(ILW+2) +: ILW+2].
  - `ps_intlevel_o` becomes DBG_LEVEL, `ps_excm_o` becomes 1, and `ps_um_o` keeps `ps_um_i`.
- R7: A debug request with `ps_intlevel_i` >= DBG_LEVEL is ignored. It produces no taken pulse and changes no register.
- R8: When a general request arrives together with an accepted debug request, only the debug entry happens, and `exccause_o`, `excvaddr_o`, EPC level 1 and `depc_o` are unchanged. When the debug request is refused, the general request proceeds.
- R9: `taken_o` is high for exactly the cycle after each accepted request. With no accepted request, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gen_req_i | input | 1 | General exception request |
| gen_addr_vld_i | input | 1 | General request carries a faulting address |
| dbg_req_i | input | 1 | Debug exception request |
| cause_i | input | CAUSE_W | Cause code |
| pc_i | input | XLEN | Faulting PC |
| vaddr_i | input | XLEN | Faulting virtual address |
| ps_intlevel_i | input | ILW | Current interrupt level |
| ps_um_i | input | 1 | Current user-mode bit |
| ps_excm_i | input | 1 | Current exception-mode bit |
| taken_o | output | 1 | Entry performed pulse |
| vector_o | output | 2 | Vector code: 0 kernel, 1 user, 2 double, 3 debug |
| ps_intlevel_o | output | ILW | New interrupt level |
| ps_um_o | output | 1 | New user-mode bit |
| ps_excm_o | output | 1 | New exception-mode bit |
| epc_flat_o | output | DBG_LEVEL*XLEN | EPC slots for levels 1..DBG_LEVEL |
| eps_flat_o | output | DBG_LEVEL*(ILW+2) | EPS slots for levels 1..DBG_LEVEL |
| depc_o | output | XLEN | Double-exception PC |
| exccause_o | output | CAUSE_W | General exception cause |
| excvaddr_o | output | XLEN | Faulting virtual address |
| debugcause_o | output | CAUSE_W | Debug cause |

## Verification
A general request and a debug request can fall in the same cycle. The outcome then depends only on the interrupt level relative to DBG_LEVEL. Directed steps raise both requests once at level 0, where debug must win and the general save registers must stay put. They raise both again at level DBG_LEVEL, where debug is refused and the general entry must proceed. Random stimulus then drives both request lines independently over the full interrupt-level range, so coincidences happen repeatedly. A bench model that applies the same priority predicts every save register after each edge, and the outputs are compared against it.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [1:0] {
    VEC_KERNEL = 2'd0,
    VEC_USER   = 2'd1,
    VEC_DOUBLE = 2'd2,
    VEC_DEBUG  = 2'd3
  } vec_e;
endpackage

// File: rtl/exc_entry_decide.sv
module exc_entry_decide
  import exc_entry_pkg::*;
#(
  parameter int ILW       = 4,
  parameter int DBG_LEVEL = 5
) (
  input  logic           gen_req_i,
  input  logic           dbg_req_i,
  input  logic [ILW-1:0] ps_intlevel_i,
  input  logic           ps_um_i,
  input  logic           ps_excm_i,
  output logic           take_gen_o,
  output logic           take_dbg_o,
  output logic           dbl_o,
  output vec_e           vec_o,
  output logic [ILW-1:0] nxt_intlevel_o,
  output logic           nxt_um_o,
  output logic           nxt_excm_o
);
  localparam logic [ILW-1:0] DBG_LVL = ILW'(DBG_LEVEL);

  // debug has priority only when it is accepted
  assign take_dbg_o = dbg_req_i && (ps_intlevel_i < DBG_LVL);
  assign take_gen_o = gen_req_i && !take_dbg_o;
  assign dbl_o      = ps_excm_i;

  always_comb begin
    nxt_um_o       = ps_um_i;
    nxt_excm_o     = 1'b1;
    nxt_intlevel_o = ps_intlevel_i;
    if (take_dbg_o) begin
      vec_o          = VEC_DEBUG;
      nxt_intlevel_o = DBG_LVL;
    end else if (ps_excm_i) begin
      vec_o = VEC_DOUBLE;
    end else if (ps_um_i) begin
      vec_o = VEC_USER;
    end else begin
      vec_o = VEC_KERNEL;
    end
  end
endmodule

// File: rtl/exc_entry_savebank.sv
module exc_entry_savebank #(
  parameter int XLEN      = 32,
  parameter int PS_W      = 6,
  parameter int DBG_LEVEL = 5,
  parameter bit HAS_DEPC  = 1'b1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      take_gen_i,
  input  logic                      take_dbg_i,
  input  logic                      dbl_i,
  input  logic [XLEN-1:0]           pc_i,
  input  logic [PS_W-1:0]           ps_word_i,
  output logic [DBG_LEVEL*XLEN-1:0] epc_flat_o,
  output logic [DBG_LEVEL*PS_W-1:0] eps_flat_o,
  output logic [XLEN-1:0]           depc_o
);
  for (genvar l = 1; l <= DBG_LEVEL; l++) begin : g_lvl
    localparam bit IS_GEN = (l == 1);
    localparam bit IS_DBG = (l == DBG_LEVEL);
    logic            epc_we, eps_we;
    logic [XLEN-1:0] epc_q;
    logic [PS_W-1:0] eps_q;

    assign epc_we = (IS_GEN && take_gen_i && !(dbl_i && HAS_DEPC)) ||
                    (IS_DBG && take_dbg_i);
    assign eps_we = IS_DBG && take_dbg_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        epc_q <= '0;
        eps_q <= '0;
      end else begin
        if (epc_we) epc_q <= pc_i;
        if (eps_we) eps_q <= ps_word_i;
      end
    end

    assign epc_flat_o[(l-1)*XLEN +: XLEN] = epc_q;
    assign eps_flat_o[(l-1)*PS_W +: PS_W] = eps_q;
  end

  if (HAS_DEPC) begin : g_depc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 depc_o <= '0;
      else if (take_gen_i && dbl_i) depc_o <= pc_i;
    end
  end else begin : g_no_depc
    assign depc_o = '0;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CAUSE_W   = 6,
  parameter int ILW       = 4,
  parameter int DBG_LEVEL = 5,
  parameter bit HAS_DEPC  = 1'b1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           gen_req_i,
  input  logic                           gen_addr_vld_i,
  input  logic                           dbg_req_i,
  input  logic [CAUSE_W-1:0]             cause_i,
  input  logic [XLEN-1:0]                pc_i,
  input  logic [XLEN-1:0]                vaddr_i,
  input  logic [ILW-1:0]                 ps_intlevel_i,
  input  logic                           ps_um_i,
  input  logic                           ps_excm_i,
  output logic                           taken_o,
  output logic [1:0]                     vector_o,
  output logic [ILW-1:0]                 ps_intlevel_o,
  output logic                           ps_um_o,
  output logic                           ps_excm_o,
  output logic [DBG_LEVEL*XLEN-1:0]      epc_flat_o,
  output logic [DBG_LEVEL*(ILW+2)-1:0]   eps_flat_o,
  output logic [XLEN-1:0]                depc_o,
  output logic [CAUSE_W-1:0]             exccause_o,
  output logic [XLEN-1:0]                excvaddr_o,
  output logic [CAUSE_W-1:0]             debugcause_o
);
  localparam int PS_W = ILW + 2;

  logic           take_gen, take_dbg, dbl;
  vec_e           vec;
  logic [ILW-1:0] nxt_il;
  logic           nxt_um, nxt_excm;
  logic           take_any;
  logic [PS_W-1:0] ps_word;

  assign take_any = take_gen || take_dbg;
  assign ps_word  = {ps_intlevel_i, ps_um_i, ps_excm_i};

  exc_entry_decide #(.ILW(ILW), .DBG_LEVEL(DBG_LEVEL)) u_decide (
    .gen_req_i      (gen_req_i),
    .dbg_req_i      (dbg_req_i),
    .ps_intlevel_i  (ps_intlevel_i),
    .ps_um_i        (ps_um_i),
    .ps_excm_i      (ps_excm_i),
    .take_gen_o     (take_gen),
    .take_dbg_o     (take_dbg),
    .dbl_o          (dbl),
    .vec_o          (vec),
    .nxt_intlevel_o (nxt_il),
    .nxt_um_o       (nxt_um),
    .nxt_excm_o     (nxt_excm)
  );

  exc_entry_savebank #(
    .XLEN(XLEN), .PS_W(PS_W), .DBG_LEVEL(DBG_LEVEL), .HAS_DEPC(HAS_DEPC)
  ) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_gen_i (take_gen),
    .take_dbg_i (take_dbg),
    .dbl_i      (dbl),
    .pc_i       (pc_i),
    .ps_word_i  (ps_word),
    .epc_flat_o (epc_flat_o),
    .eps_flat_o (eps_flat_o),
    .depc_o     (depc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o       <= 1'b0;
      vector_o      <= VEC_KERNEL;
      ps_intlevel_o <= '0;
      ps_um_o       <= 1'b0;
      ps_excm_o     <= 1'b0;
      exccause_o    <= '0;
      excvaddr_o    <= '0;
      debugcause_o  <= '0;
    end else begin
      taken_o <= take_any;
      if (take_any) begin
        vector_o      <= vec;
        ps_intlevel_o <= nxt_il;
        ps_um_o       <= nxt_um;
        ps_excm_o     <= nxt_excm;
      end
      if (take_gen) begin
        exccause_o <= cause_i;
        if (gen_addr_vld_i) excvaddr_o <= vaddr_i;
      end
      if (take_dbg) debugcause_o <= cause_i;
    end
  end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk #(
  parameter int CAUSE_W   = 6,
  parameter int ILW       = 4,
  parameter int DBG_LEVEL = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               gen_req_i,
  input logic               dbg_req_i,
  input logic [CAUSE_W-1:0] cause_i,
  input logic [ILW-1:0]     ps_intlevel_i,
  input logic               ps_excm_i,
  input logic               taken_o,
  input logic [1:0]         vector_o,
  input logic [ILW-1:0]     ps_intlevel_o,
  input logic               ps_excm_o,
  input logic [CAUSE_W-1:0] exccause_o,
  input logic [CAUSE_W-1:0] debugcause_o
);
  logic dbg_ok;
  assign dbg_ok = dbg_req_i && (ps_intlevel_i < ILW'(DBG_LEVEL));

  assert_take_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_req_i || dbg_ok) |=> taken_o);
  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gen_req_i && !dbg_req_i) |=> !taken_o);
  assert_excm_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> ps_excm_o);
  assert_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_req_i && !dbg_ok) |=> exccause_o == $past(cause_i));
  assert_double_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_req_i && !dbg_ok && ps_excm_i) |=> vector_o == 2'd2);
  assert_debug_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_ok |=> (vector_o == 2'd3) && (ps_intlevel_o == ILW'(DBG_LEVEL)));
  assert_ignore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_req_i && !dbg_ok && !gen_req_i) |=> !taken_o && $stable(debugcause_o));
  assert_win_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_req_i && dbg_ok) |=> $stable(exccause_o));
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(
  .CAUSE_W(CAUSE_W), .ILW(ILW), .DBG_LEVEL(DBG_LEVEL)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .gen_req_i     (gen_req_i),
  .dbg_req_i     (dbg_req_i),
  .cause_i       (cause_i),
  .ps_intlevel_i (ps_intlevel_i),
  .ps_excm_i     (ps_excm_i),
  .taken_o       (taken_o),
  .vector_o      (vector_o),
  .ps_intlevel_o (ps_intlevel_o),
  .ps_excm_o     (ps_excm_o),
  .exccause_o    (exccause_o),
  .debugcause_o  (debugcause_o)
);

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int CW   = 6;
  localparam int ILW  = 4;
  localparam int DBG  = 5;
  localparam int PSW  = ILW + 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic            gen_req = 0, addr_vld = 0, dbg_req = 0;
  logic [CW-1:0]   cause = '0;
  logic [XLEN-1:0] pc = '0, vaddr = '0;
  logic [ILW-1:0]  il = '0;
  logic            um = 0, excm = 0;

  logic                 taken, um_o, excm_o;
  logic [1:0]           vec;
  logic [ILW-1:0]       il_o;
  logic [DBG*XLEN-1:0]  epc_f;
  logic [DBG*PSW-1:0]   eps_f;
  logic [XLEN-1:0]      depc, evaddr;
  logic [CW-1:0]        ecause, dcause;

  logic                 n_taken, n_um_o, n_excm_o;
  logic [1:0]           n_vec;
  logic [ILW-1:0]       n_il_o;
  logic [DBG*XLEN-1:0]  n_epc_f;
  logic [DBG*PSW-1:0]   n_eps_f;
  logic [XLEN-1:0]      n_depc, n_evaddr;
  logic [CW-1:0]        n_ecause, n_dcause;

  exc_entry_ctrl #(.XLEN(XLEN), .CAUSE_W(CW), .ILW(ILW), .DBG_LEVEL(DBG), .HAS_DEPC(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .gen_req_i(gen_req), .gen_addr_vld_i(addr_vld),
    .dbg_req_i(dbg_req), .cause_i(cause), .pc_i(pc), .vaddr_i(vaddr),
    .ps_intlevel_i(il), .ps_um_i(um), .ps_excm_i(excm),
    .taken_o(taken), .vector_o(vec), .ps_intlevel_o(il_o), .ps_um_o(um_o), .ps_excm_o(excm_o),
    .epc_flat_o(epc_f), .eps_flat_o(eps_f), .depc_o(depc), .exccause_o(ecause),
    .excvaddr_o(evaddr), .debugcause_o(dcause));

  exc_entry_ctrl #(.XLEN(XLEN), .CAUSE_W(CW), .ILW(ILW), .DBG_LEVEL(DBG), .HAS_DEPC(1'b0)) uut_nd (
    .clk_i(clk), .rst_ni(rst_ni), .gen_req_i(gen_req), .gen_addr_vld_i(addr_vld),
    .dbg_req_i(dbg_req), .cause_i(cause), .pc_i(pc), .vaddr_i(vaddr),
    .ps_intlevel_i(il), .ps_um_i(um), .ps_excm_i(excm),
    .taken_o(n_taken), .vector_o(n_vec), .ps_intlevel_o(n_il_o), .ps_um_o(n_um_o), .ps_excm_o(n_excm_o),
    .epc_flat_o(n_epc_f), .eps_flat_o(n_eps_f), .depc_o(n_depc), .exccause_o(n_ecause),
    .excvaddr_o(n_evaddr), .debugcause_o(n_dcause));

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic            m_taken = 0, m_um = 0, m_excm = 0;
  logic [1:0]      m_vec = 0;
  logic [ILW-1:0]  m_il = 0;
  logic [XLEN-1:0] m_epc [1:DBG];
  logic [PSW-1:0]  m_eps [1:DBG];
  logic [XLEN-1:0] m_depc = 0, m_vaddr = 0, m_nd_epc1 = 0;
  logic [CW-1:0]   m_ecause = 0, m_dcause = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk({tag, "/R9"}, "taken", 64'(taken), 64'(m_taken));
    chk({tag, "/R2"}, "vector", 64'(vec), 64'(m_vec));
    chk({tag, "/R4"}, "ps_intlevel", 64'(il_o), 64'(m_il));
    chk({tag, "/R4"}, "ps_um", 64'(um_o), 64'(m_um));
    chk({tag, "/R4"}, "ps_excm", 64'(excm_o), 64'(m_excm));
    for (int l = 1; l <= DBG; l++) begin
      chk({tag, "/R6"}, $sformatf("epc%0d", l), 64'(epc_f[(l-1)*XLEN +: XLEN]), 64'(m_epc[l]));
      chk({tag, "/R6"}, $sformatf("eps%0d", l), 64'(eps_f[(l-1)*PSW +: PSW]), 64'(m_eps[l]));
    end
    chk({tag, "/R3"}, "depc", 64'(depc), 64'(m_depc));
    chk({tag, "/R4"}, "exccause", 64'(ecause), 64'(m_ecause));
    chk({tag, "/R5"}, "excvaddr", 64'(evaddr), 64'(m_vaddr));
    chk({tag, "/R6"}, "debugcause", 64'(dcause), 64'(m_dcause));
    chk({tag, "/R3"}, "nodepc_epc1", 64'(n_epc_f[XLEN-1:0]), 64'(m_nd_epc1));
    chk({tag, "/R3"}, "nodepc_depc", 64'(n_depc), 64'd0);
  endtask

  task automatic step(bit g, bit v, bit d, logic [CW-1:0] c, logic [XLEN-1:0] p,
                      logic [XLEN-1:0] va, logic [ILW-1:0] lv, bit u, bit e, string tag);
    bit dok, gt;
    @(negedge clk);
    gen_req = g; addr_vld = v; dbg_req = d; cause = c; pc = p; vaddr = va;
    il = lv; um = u; excm = e;
    @(posedge clk);
    #1;
    dok = d && (lv < ILW'(DBG));
    gt  = g && !dok;
    m_taken = dok || gt;
    if (dok) begin
      m_vec = 2'd3; m_dcause = c; m_epc[DBG] = p; m_eps[DBG] = {lv, u, e};
      m_il = ILW'(DBG); m_um = u; m_excm = 1'b1;
    end else if (gt) begin
      m_vec = e ? 2'd2 : (u ? 2'd1 : 2'd0);
      if (e) m_depc = p; else m_epc[1] = p;
      m_nd_epc1 = p;
      m_ecause = c;
      if (v) m_vaddr = va;
      m_il = lv; m_um = u; m_excm = 1'b1;
    end
    compare_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int l = 1; l <= DBG; l++) begin m_epc[l] = '0; m_eps[l] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    compare_all("R1");

    step(1, 1, 0, 6'd3,  32'h0000_1000, 32'hdead_0004, 4'd0, 0, 0, "R2_kernel");
    step(1, 0, 0, 6'd7,  32'h0000_2000, 32'hbeef_0000, 4'd2, 1, 0, "R5_user_noaddr");
    step(1, 1, 0, 6'd9,  32'h0000_3000, 32'h1234_5678, 4'd1, 0, 1, "R3_double");
    step(0, 0, 1, 6'd1,  32'h0000_4000, 32'h0,         4'(DBG-1), 1, 1, "R6_dbg_accept");
    step(0, 0, 1, 6'd2,  32'h0000_5000, 32'h0,         4'(DBG), 0, 0, "R7_dbg_reject");
    step(0, 0, 0, 6'd2,  32'h0000_5004, 32'h0,         4'd0, 0, 0, "R9_idle");
    step(1, 1, 1, 6'd11, 32'h0000_6000, 32'hcafe_0000, 4'd0, 0, 0, "R8_dbg_wins");
    step(1, 1, 1, 6'd12, 32'h0000_7000, 32'hf00d_0000, 4'(DBG), 1, 0, "R8_gen_proceeds");
    step(0, 0, 0, 6'd0,  32'h0, 32'h0, 4'd0, 0, 0, "R9_idle");

    for (int i = 0; i < 600; i++) begin
      step(($urandom % 3) == 0, $urandom % 2, ($urandom % 3) == 0,
           CW'($urandom), $urandom, $urandom, ILW'($urandom),
           $urandom % 2, $urandom % 2, "RND");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule